// File: doc/BRIEF.md
# Integration test register multiplexer

This block sits around a small general-purpose I/O peripheral and gives test software a way to prove that the peripheral's intra-chip connections are wired correctly, using only register accesses over APB. A control bit puts the block into integration-test mode. In that mode, four 8-bit buses stop carrying their functional values. Each one instead carries a value held in a test register. Two of these buses run toward the peripheral core: alternate-function data in, and alternate-function enable, which is active low. The other two run toward the chip: the masked interrupt status, and alternate-function data out toward the pads.

Reads of the test registers return each bus as it appears at the multiplexer output, not the stored value. One test register cannot be read at its own offset: the masked interrupt status. Its content is seen through the masked-status read offset while test mode is on. A combined interrupt line is the OR of the multiplexed status bus. Its level can be read at a read-only offset.

In normal mode every multiplexer passes its functional signal straight through. Writes to the test registers are still stored, so software can preload values before it switches modes.

Top module: `gpio_itest_mux`

## Requirements
- R1: After reset, test mode is off and every stored test value is zero, so outputs equal their functional inputs and the first switch into test mode drives zeros.
- R2: Bit 0 of offset 0x600 is the test enable (1 = test mode); it reads back in bit 0 and all other bits of that offset read as zero; only bit 0 of a write has an effect.
- R3: While test mode is off, each of the four outputs equals its functional input, and writes to 0x604, 0x608, 0x60C and 0x614 are stored without changing any output; the stored values appear once test mode is entered.
- R4: In test mode, the value written to 0x604 bits 7:0 drives the core-side alternate-function data bus; reads of 0x604 return that bus at the multiplexer output.
- R5: In test mode, the value written to 0x608 bits 7:0 drives the core-side active-low alternate-function enable bus; reads of 0x608 return that bus at the multiplexer output.
- R6: In test mode, the value written to 0x60C bits 7:0 drives the chip-side masked status bus; reads of 0x60C always return zero.
- R7: Reads of 0x418 return the multiplexed masked status bus in bits 7:0: the 0x60C value in test mode, the core's masked status otherwise.
- R8: The combined interrupt output is high exactly when any bit of the multiplexed masked status bus is 1; reads of 0x610 return it in bit 0, and writes to 0x610 and 0x418 change nothing.
- R9: In test mode, the value written to 0x614 bits 7:0 drives the pad-side alternate-function output bus; reads of 0x614 return that bus at the multiplexer output.
- R10: Every access completes without wait states (pready high, pslverr low); reads of unmapped offsets return zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | Byte offset within the peripheral |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always low |
| sys_afdata_i | input | 8 | Functional alternate-function data toward the core |
| sys_afen_n_i | input | 8 | Functional active-low alternate-function enable toward the core |
| core_afdata_o | output | 8 | Multiplexed alternate-function data into the core |
| core_afen_n_o | output | 8 | Multiplexed alternate-function enable into the core |
| core_mis_i | input | 8 | Core masked interrupt status |
| chip_mis_o | output | 8 | Multiplexed masked interrupt status |
| chip_intr_o | output | 1 | Combined interrupt, OR of chip_mis_o |
| core_afout_i | input | 8 | Core alternate-function output data |
| chip_afout_o | output | 8 | Multiplexed alternate-function output toward the pads |

## Verification
Two kinds of event can fall in the same clock. One is a register write that flips the mode bit or reloads a test value. The other is a change on a functional input bus. The bench drives new random values onto all functional inputs on every cycle, so every mode switch and every reload lands together with an input change. A behavioural model, updated from the bench's own stimulus, predicts all outputs and the combined interrupt on every clock. The model also predicts each read result during its access phase. Any cycle in which an output follows the wrong source, or switches one cycle early or late, is reported as a mismatch.

// File: rtl/itest_pkg.sv
package itest_pkg;

  localparam int OFS_W = 12;
  localparam int WA_W  = OFS_W - 2;

  localparam logic [OFS_W-1:0] OFS_MIS  = 12'h418;
  localparam logic [OFS_W-1:0] OFS_CTRL = 12'h600;
  localparam logic [OFS_W-1:0] OFS_AFD  = 12'h604;
  localparam logic [OFS_W-1:0] OFS_AFEN = 12'h608;
  localparam logic [OFS_W-1:0] OFS_MSET = 12'h60C;
  localparam logic [OFS_W-1:0] OFS_INTR = 12'h610;
  localparam logic [OFS_W-1:0] OFS_AFO  = 12'h614;

  // multiplexer lanes
  localparam int NLANE   = 4;
  localparam int LN_AFD  = 0;
  localparam int LN_AFEN = 1;
  localparam int LN_MIS  = 2;
  localparam int LN_AFO  = 3;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_AFD, SEL_AFEN, SEL_MSET, SEL_INTR, SEL_AFO, SEL_MIS
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic [WA_W-1:0] wa);
    reg_sel_e s;
    s = SEL_NONE;
    if (wa == OFS_CTRL[OFS_W-1:2]) s = SEL_CTRL;
    if (wa == OFS_AFD[OFS_W-1:2])  s = SEL_AFD;
    if (wa == OFS_AFEN[OFS_W-1:2]) s = SEL_AFEN;
    if (wa == OFS_MSET[OFS_W-1:2]) s = SEL_MSET;
    if (wa == OFS_INTR[OFS_W-1:2]) s = SEL_INTR;
    if (wa == OFS_AFO[OFS_W-1:2])  s = SEL_AFO;
    if (wa == OFS_MIS[OFS_W-1:2])  s = SEL_MIS;
    return s;
  endfunction

  function automatic logic is_writable(input reg_sel_e s);
    return (s == SEL_CTRL) || (s == SEL_AFD) || (s == SEL_AFEN) ||
           (s == SEL_MSET) || (s == SEL_AFO);
  endfunction

endpackage

// File: rtl/itest_regs.sv
module itest_regs
  import itest_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  reg_sel_e      wr_sel_i,
  input  logic [GW-1:0] wdata_i,
  output logic          test_en_o,
  output logic [GW-1:0] afd_q_o,
  output logic [GW-1:0] afen_q_o,
  output logic [GW-1:0] mset_q_o,
  output logic [GW-1:0] afo_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_en_o <= 1'b0;
      afd_q_o   <= '0;
      afen_q_o  <= '0;
      mset_q_o  <= '0;
      afo_q_o   <= '0;
    end else if (wr_stb_i) begin
      case (wr_sel_i)
        SEL_CTRL: test_en_o <= wdata_i[0];
        SEL_AFD:  afd_q_o   <= wdata_i;
        SEL_AFEN: afen_q_o  <= wdata_i;
        SEL_MSET: mset_q_o  <= wdata_i;
        SEL_AFO:  afo_q_o   <= wdata_i;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/itest_mux.sv
module itest_mux #(
  parameter int GW = 8
) (
  input  logic          test_en_i,
  input  logic [GW-1:0] func_i,
  input  logic [GW-1:0] test_i,
  output logic [GW-1:0] out_o
);

  assign out_o = test_en_i ? test_i : func_i;

endmodule

// File: rtl/itest_rdmux.sv
module itest_rdmux
  import itest_pkg::*;
#(
  parameter int GW = 8,
  parameter int DW = 32
) (
  input  reg_sel_e      rd_sel_i,
  input  logic          test_en_i,
  input  logic [GW-1:0] afd_i,
  input  logic [GW-1:0] afen_i,
  input  logic [GW-1:0] mis_i,
  input  logic          intr_i,
  input  logic [GW-1:0] afo_i,
  output logic [DW-1:0] prdata_o,
  output logic          hit_o
);

  always_comb begin
    prdata_o = '0;
    hit_o    = 1'b1;
    case (rd_sel_i)
      SEL_CTRL: prdata_o[0]      = test_en_i;
      SEL_AFD:  prdata_o[GW-1:0] = afd_i;
      SEL_AFEN: prdata_o[GW-1:0] = afen_i;
      SEL_MSET: prdata_o         = '0;
      SEL_INTR: prdata_o[0]      = intr_i;
      SEL_AFO:  prdata_o[GW-1:0] = afo_i;
      SEL_MIS:  prdata_o[GW-1:0] = mis_i;
      default:  hit_o            = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_itest_mux.sv
module gpio_itest_mux
  import itest_pkg::*;
#(
  parameter int GW = 8,
  parameter int DW = 32
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [OFS_W-1:0] paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  output logic             pready,
  output logic             pslverr,
  input  logic [GW-1:0]    sys_afdata_i,
  input  logic [GW-1:0]    sys_afen_n_i,
  output logic [GW-1:0]    core_afdata_o,
  output logic [GW-1:0]    core_afen_n_o,
  input  logic [GW-1:0]    core_mis_i,
  output logic [GW-1:0]    chip_mis_o,
  output logic             chip_intr_o,
  input  logic [GW-1:0]    core_afout_i,
  output logic [GW-1:0]    chip_afout_o
);

  reg_sel_e acc_sel;
  reg_sel_e rd_sel;
  logic     wr_stb;
  logic     test_en;
  logic     rd_hit;
  logic [GW-1:0] afd_q, afen_q, mset_q, afo_q;
  logic [NLANE-1:0][GW-1:0] func_bus, test_bus, out_bus;
  logic unused_bits;

  assign unused_bits = ^{paddr[1:0], pwdata[DW-1:GW]};

  assign acc_sel = decode_word(paddr[OFS_W-1:2]);
  assign wr_stb  = psel && penable && pwrite && is_writable(acc_sel);
  assign rd_sel  = (psel && !pwrite) ? acc_sel : SEL_NONE;

  itest_regs #(.GW(GW)) u_regs (
    .clk_i     (pclk),
    .rst_ni    (presetn),
    .wr_stb_i  (wr_stb),
    .wr_sel_i  (acc_sel),
    .wdata_i   (pwdata[GW-1:0]),
    .test_en_o (test_en),
    .afd_q_o   (afd_q),
    .afen_q_o  (afen_q),
    .mset_q_o  (mset_q),
    .afo_q_o   (afo_q)
  );

  assign func_bus[LN_AFD]  = sys_afdata_i;
  assign func_bus[LN_AFEN] = sys_afen_n_i;
  assign func_bus[LN_MIS]  = core_mis_i;
  assign func_bus[LN_AFO]  = core_afout_i;
  assign test_bus[LN_AFD]  = afd_q;
  assign test_bus[LN_AFEN] = afen_q;
  assign test_bus[LN_MIS]  = mset_q;
  assign test_bus[LN_AFO]  = afo_q;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    itest_mux #(.GW(GW)) u_mux (
      .test_en_i (test_en),
      .func_i    (func_bus[g]),
      .test_i    (test_bus[g]),
      .out_o     (out_bus[g])
    );
  end

  assign core_afdata_o = out_bus[LN_AFD];
  assign core_afen_n_o = out_bus[LN_AFEN];
  assign chip_mis_o    = out_bus[LN_MIS];
  assign chip_afout_o  = out_bus[LN_AFO];
  assign chip_intr_o   = |out_bus[LN_MIS];

  itest_rdmux #(.GW(GW), .DW(DW)) u_rd (
    .rd_sel_i  (rd_sel),
    .test_en_i (test_en),
    .afd_i     (out_bus[LN_AFD]),
    .afen_i    (out_bus[LN_AFEN]),
    .mis_i     (out_bus[LN_MIS]),
    .intr_i    (chip_intr_o),
    .afo_i     (out_bus[LN_AFO]),
    .prdata_o  (prdata),
    .hit_o     (rd_hit)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/gpio_itest_chk.sv
module gpio_itest_chk
  import itest_pkg::*;
#(
  parameter int GW = 8,
  parameter int DW = 32
) (
  input logic             pclk,
  input logic             presetn,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [OFS_W-1:0] paddr,
  input logic [DW-1:0]    pwdata,
  input logic [DW-1:0]    prdata,
  input logic             test_en,
  input logic             rd_hit,
  input logic [GW-1:0]    sys_afdata_i,
  input logic [GW-1:0]    core_afdata_o,
  input logic [GW-1:0]    chip_mis_o,
  input logic             chip_intr_o,
  input logic [GW-1:0]    chip_afout_o
);

  logic wr_acc;
  assign wr_acc = psel && penable && pwrite;

  p_mode_load_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_acc && paddr == OFS_CTRL) |=> (test_en == $past(pwdata[0])));

  p_pass_afd_r3: assert property (@(posedge pclk) disable iff (!presetn)
    !test_en |-> (core_afdata_o == sys_afdata_i));

  p_afd_drive_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (test_en && wr_acc && paddr == OFS_AFD) |=> (core_afdata_o == $past(pwdata[GW-1:0])));

  p_mis_drive_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (test_en && wr_acc && paddr == OFS_MSET) |=> (chip_mis_o == $past(pwdata[GW-1:0])));

  p_intr_or_r8: assert property (@(posedge pclk) disable iff (!presetn)
    chip_intr_o == (chip_mis_o != '0));

  p_afo_drive_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (test_en && wr_acc && paddr == OFS_AFO) |=> (chip_afout_o == $past(pwdata[GW-1:0])));

  p_unmapped_zero_r10: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && !rd_hit) |-> (prdata == '0));

endmodule

bind gpio_itest_mux gpio_itest_chk #(.GW(GW), .DW(DW)) u_chk (
  .pclk          (pclk),
  .presetn       (presetn),
  .psel          (psel),
  .penable       (penable),
  .pwrite        (pwrite),
  .paddr         (paddr),
  .pwdata        (pwdata),
  .prdata        (prdata),
  .test_en       (test_en),
  .rd_hit        (rd_hit),
  .sys_afdata_i  (sys_afdata_i),
  .core_afdata_o (core_afdata_o),
  .chip_mis_o    (chip_mis_o),
  .chip_intr_o   (chip_intr_o),
  .chip_afout_o  (chip_afout_o)
);

// File: tb/gpio_itest_mux_tb.sv
module gpio_itest_mux_tb;
  localparam int GW = 8;
  localparam int DW = 32;

  logic pclk = 1'b0;
  always #5 pclk = ~pclk;

  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic pready, pslverr;
  logic [GW-1:0] sys_afdata_i = '0, sys_afen_n_i = '0, core_mis_i = '0, core_afout_i = '0;
  logic [GW-1:0] core_afdata_o, core_afen_n_o, chip_mis_o, chip_afout_o;
  logic chip_intr_o;

  gpio_itest_mux #(.GW(GW), .DW(DW)) u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .sys_afdata_i(sys_afdata_i), .sys_afen_n_i(sys_afen_n_i),
    .core_afdata_o(core_afdata_o), .core_afen_n_o(core_afen_n_o),
    .core_mis_i(core_mis_i), .chip_mis_o(chip_mis_o), .chip_intr_o(chip_intr_o),
    .core_afout_i(core_afout_i), .chip_afout_o(chip_afout_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model state
  bit            m_en = 0;
  logic [GW-1:0] m_afd = '0, m_afen = '0, m_mset = '0, m_afo = '0;

  function automatic logic [GW-1:0] x_afd();  return m_en ? m_afd  : sys_afdata_i; endfunction
  function automatic logic [GW-1:0] x_afen(); return m_en ? m_afen : sys_afen_n_i; endfunction
  function automatic logic [GW-1:0] x_mis();  return m_en ? m_mset : core_mis_i;   endfunction
  function automatic logic [GW-1:0] x_afo();  return m_en ? m_afo  : core_afout_i; endfunction
  function automatic logic x_intr(); return x_mis() != 0; endfunction

  function automatic logic [DW-1:0] x_read(input logic [11:0] a);
    logic [DW-1:0] r;
    r = '0;
    case (a)
      12'h600: r[0] = m_en;
      12'h604: r[GW-1:0] = x_afd();
      12'h608: r[GW-1:0] = x_afen();
      12'h610: r[0] = x_intr();
      12'h614: r[GW-1:0] = x_afo();
      12'h418: r[GW-1:0] = x_mis();
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update and per-cycle comparison
  always @(posedge pclk) begin
    if (!presetn) begin
      m_en = 0; m_afd = '0; m_afen = '0; m_mset = '0; m_afo = '0;
    end else if (psel && penable && pwrite) begin
      case (paddr)
        12'h600: m_en   = pwdata[0];
        12'h604: m_afd  = pwdata[GW-1:0];
        12'h608: m_afen = pwdata[GW-1:0];
        12'h60C: m_mset = pwdata[GW-1:0];
        12'h614: m_afo  = pwdata[GW-1:0];
        default: ;
      endcase
    end
    #2;
    if (!done) begin
      if (!presetn) begin
        check("R1 reset afd out", DW'(core_afdata_o), DW'(x_afd()));
        check("R1 reset mis out", DW'(chip_mis_o), DW'(x_mis()));
      end else begin
        check(m_en ? "R4 afd out" : "R3 afd out",  DW'(core_afdata_o), DW'(x_afd()));
        check(m_en ? "R5 afen out" : "R3 afen out", DW'(core_afen_n_o), DW'(x_afen()));
        check(m_en ? "R6 mis out" : "R3 mis out",  DW'(chip_mis_o), DW'(x_mis()));
        check(m_en ? "R9 afo out" : "R3 afo out",  DW'(chip_afout_o), DW'(x_afo()));
        check("R8 intr out", DW'(chip_intr_o), DW'(x_intr()));
        check("R10 pready", DW'(pready), 1);
        check("R10 pslverr", DW'(pslverr), 0);
      end
    end
  end

  // functional inputs change on every cycle
  always @(negedge pclk) begin
    sys_afdata_i = GW'($urandom);
    sys_afen_n_i = GW'($urandom);
    core_mis_i   = GW'($urandom);
    core_afout_i = GW'($urandom);
  end

  task automatic apb_wr(input logic [11:0] a, input logic [DW-1:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, input string tag);
    @(negedge pclk);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    #2;
    check(tag, prdata, x_read(a));
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge pclk);
    presetn = 1;

    apb_rd(12'h600, "R1 ctrl after reset");
    apb_rd(12'h604, "R3 normal read afd");
    apb_rd(12'h60C, "R6 write-only reads zero");
    apb_rd(12'h7FC, "R10 unmapped read");

    apb_wr(12'h600, 32'h1);
    apb_rd(12'h600, "R2 enable read back");
    apb_rd(12'h604, "R1 reset value afd");
    apb_rd(12'h614, "R1 reset value afo");
    apb_rd(12'h610, "R8 intr low after reset");

    apb_wr(12'h604, 32'hA5);
    apb_rd(12'h604, "R4 afd read");
    apb_wr(12'h608, 32'h3C);
    apb_rd(12'h608, "R5 afen read");
    apb_wr(12'h60C, 32'h0);
    apb_rd(12'h610, "R8 intr zero");
    apb_wr(12'h60C, 32'h80);
    apb_rd(12'h610, "R8 intr top bit");
    apb_rd(12'h418, "R7 mis shows set value");
    apb_rd(12'h60C, "R6 write-only reads zero");
    apb_wr(12'h614, 32'h5A);
    apb_rd(12'h614, "R9 afo read");

    apb_wr(12'h610, 32'hFF);
    apb_wr(12'h418, 32'hFF);
    apb_wr(12'h7FC, 32'hFFFF_FFFF);
    apb_rd(12'h418, "R8 read-only writes ignored");
    apb_rd(12'h7FC, "R10 unmapped stays zero");

    apb_wr(12'h600, 32'hFFFF_FFFE);
    apb_rd(12'h600, "R2 only bit0 counts");
    apb_wr(12'h604, 32'h11);
    apb_wr(12'h60C, 32'h22);
    apb_wr(12'h614, 32'h33);
    apb_rd(12'h604, "R3 normal after write");
    apb_rd(12'h418, "R7 normal mis");
    apb_wr(12'h600, 32'h1);
    apb_rd(12'h604, "R3 stored value appears");
    apb_rd(12'h418, "R7 stored mis appears");
    apb_rd(12'h614, "R9 stored afo appears");

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      case ($urandom % 9)
        0: a = 12'h600; 1: a = 12'h604; 2: a = 12'h608; 3: a = 12'h60C;
        4: a = 12'h610; 5: a = 12'h614; 6: a = 12'h418; 7: a = 12'h700;
        default: a = 12'h600;
      endcase
      if ($urandom % 2) apb_wr(a, $urandom);
      else apb_rd(a, "R10 random read");
    end

    repeat (2) @(negedge pclk);
    finish_run();
  end

endmodule